// File: doc/BRIEF.md
# Successive-Approximation Converter Controller with Port Interface

This block sequences an n-bit successive-approximation analog-to-digital conversion and presents it to a processor as three I/O ports. The processor writes to the start port to launch a conversion. It polls the status port until the busy flag clears, then reads the converted code from the data port. The DAC that produces the trial level and the comparator that judges it sit outside the block. The block drives the trial code to the DAC and samples the comparator's one-bit verdict.

The search is a binary search run by a two-state machine. The state `IDLE` waits for a start. Transition `IDLE -> CONVERT` fires on a start write. The state `CONVERT` decides one bit per clock, highest bit first. Transition `CONVERT -> CONVERT` takes each step and also serves as the restart path. Transition `CONVERT -> IDLE` fires when the lowest bit has been decided. On that transition the finished code is copied into the result register.

Each decision also appears on a serial output with a one-cycle strobe. A downstream consumer can therefore take the code most-significant bit first, without waiting for the end of the conversion.

Top module: `sar_port_ctrl`

## Requirements
- R1: A write strobe with address `BASE_ADDR+2` starts a conversion. On the next cycle the state is CONVERT and `dac_code` holds only its top bit set (half scale).
- R2: In each CONVERT cycle the bit under trial is handled as follows. It is kept when `cmp_above` is 1 and cleared when `cmp_above` is 0. The next lower bit is set as the new trial. With `cmp_above = (level >= dac_code)`, the final result equals `level`.
- R3: A conversion spends exactly `WIDTH` clock cycles in CONVERT and then returns to IDLE.
- R4: One cycle after each decision, `ser_valid` is high for one cycle and `ser_bit` equals the decided bit. The bits come highest first, `WIDTH` strobes per conversion, and there are no strobes while idle.
- R5: A read of `BASE_ADDR+0` returns the busy flag in data bit 0 (1 = converting, 0 = idle). All higher data bits read 0.
- R6: A read of `BASE_ADDR+1` returns the last completed result, zero-extended to the bus width. This value changes only when a conversion completes.
- R7: A start write during a conversion abandons the current search. The next cycle again holds only the top bit, and a full `WIDTH`-cycle conversion follows.
- R8: `io_rdata` is 0 when `io_rd` is low or when the address is not a read port. A write to `BASE_ADDR+0` or `BASE_ADDR+1` starts nothing.
- R9: After reset the block is idle, with result 0, `dac_code` 0 and `ser_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | Port address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_rdata | output | 8 | Read data for the selected port |
| dac_code | output | WIDTH | Trial code to the external DAC |
| cmp_above | input | 1 | Comparator verdict: 1 when the analog input is at or above the trial level |
| ser_bit | output | 1 | Most recently decided bit |
| ser_valid | output | 1 | Strobe qualifying `ser_bit` |

## Verification
The assertions assume that `cmp_above` is settled before each clock edge, as the combinational result of the current `dac_code`. They also assume that the read strobe is only ever paired with a stable address. The bench builds the comparator from `dac_code` with a `>=` against a held integer level. It changes that level only between conversions, or at the same moment as a restart. All port strobes are driven on falling edges. An 8-bit configuration is swept over every level, and the expected code is the level itself.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_CONVERT = 1'b1
    } sar_state_t;
endpackage

// File: rtl/sar_port_decode.sv
module sar_port_decode #(
    parameter int          WIDTH     = 8,
    parameter int          DW        = 8,
    parameter logic [7:0]  BASE_ADDR = 8'h80
) (
    input  logic [7:0]       io_addr,
    input  logic             io_rd,
    input  logic             io_wr,
    input  logic             busy,
    input  logic [WIDTH-1:0] result,
    output logic             start,
    output logic [DW-1:0]    io_rdata
);
    localparam logic [7:0] ADDR_STAT  = BASE_ADDR;
    localparam logic [7:0] ADDR_DATA  = BASE_ADDR + 8'd1;
    localparam logic [7:0] ADDR_START = BASE_ADDR + 8'd2;

    assign start = io_wr && (io_addr == ADDR_START);

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (io_addr == ADDR_STAT) begin
                io_rdata[0] = busy;
            end else if (io_addr == ADDR_DATA) begin
                io_rdata = DW'(result);
            end
        end
    end
endmodule

// File: rtl/sar_search.sv
module sar_search
    import sar_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_above,
    output logic             busy,
    output logic [WIDTH-1:0] dac_code,
    output logic [WIDTH-1:0] result,
    output logic             ser_bit,
    output logic             ser_valid
);
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [IW-1:0]    TOP_IDX  = IW'(WIDTH - 1);
    localparam logic [WIDTH-1:0] HALF_CODE = WIDTH'(1) << (WIDTH - 1);

    sar_state_t       st, st_nx;
    logic [IW-1:0]    idx;
    logic [WIDTH-1:0] sar;
    logic [WIDTH-1:0] sar_step;
    logic             last_step;

    assign busy      = (st == ST_CONVERT);
    assign dac_code  = sar;
    assign last_step = (idx == '0);

    // Decide the bit under trial and raise the next lower one.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            if (i == int'(idx)) begin
                sar_step[i] = cmp_above;
            end else if (i + 1 == int'(idx)) begin
                sar_step[i] = 1'b1;
            end else begin
                sar_step[i] = sar[i];
            end
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:    st_nx = start ? ST_CONVERT : ST_IDLE;
            ST_CONVERT: begin
                if (start)          st_nx = ST_CONVERT;
                else if (last_step) st_nx = ST_IDLE;
                else                st_nx = ST_CONVERT;
            end
            default:    st_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Datapath and outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar       <= '0;
            idx       <= '0;
            result    <= '0;
            ser_bit   <= 1'b0;
            ser_valid <= 1'b0;
        end else begin
            ser_valid <= 1'b0;
            if (start) begin
                sar <= HALF_CODE;
                idx <= TOP_IDX;
            end else if (st == ST_CONVERT) begin
                sar       <= sar_step;
                ser_bit   <= cmp_above;
                ser_valid <= 1'b1;
                idx       <= idx - IW'(1);
                if (last_step) result <= sar_step;
            end
        end
    end
endmodule

// File: rtl/sar_port_ctrl.sv
module sar_port_ctrl #(
    parameter int         WIDTH     = 8,
    parameter logic [7:0] BASE_ADDR = 8'h80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       io_addr,
    input  logic             io_rd,
    input  logic             io_wr,
    output logic [7:0]       io_rdata,
    output logic [WIDTH-1:0] dac_code,
    input  logic             cmp_above,
    output logic             ser_bit,
    output logic             ser_valid
);
    logic             start;
    logic             busy;
    logic [WIDTH-1:0] result;

    sar_port_decode #(.WIDTH(WIDTH), .DW(8), .BASE_ADDR(BASE_ADDR)) u_decode (
        .io_addr (io_addr),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .busy    (busy),
        .result  (result),
        .start   (start),
        .io_rdata(io_rdata)
    );

    sar_search #(.WIDTH(WIDTH)) u_search (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmp_above(cmp_above),
        .busy     (busy),
        .dac_code (dac_code),
        .result   (result),
        .ser_bit  (ser_bit),
        .ser_valid(ser_valid)
    );
endmodule

// File: rtl/sar_port_ctrl_chk.sv
module sar_port_ctrl_chk #(
    parameter int         WIDTH     = 8,
    parameter logic [7:0] BASE_ADDR = 8'h80
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic [WIDTH-1:0] dac_code,
    input logic [WIDTH-1:0] result,
    input logic             ser_valid,
    input logic             io_rd,
    input logic [7:0]       io_addr,
    input logic [7:0]       io_rdata
);
    localparam logic [WIDTH-1:0] HALF_CODE = WIDTH'(1) << (WIDTH - 1);

    logic [15:0] busy_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     busy_cnt <= '0;
        else if (start) busy_cnt <= '0;
        else if (busy)  busy_cnt <= busy_cnt + 16'd1;
    end

    assert_start_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && dac_code == HALF_CODE));
    assert_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == 16'(WIDTH)));
    assert_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> ser_valid);
    assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !ser_valid);
    assert_status_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == BASE_ADDR) |-> (io_rdata[7:1] == 7'd0));
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(result));
endmodule

bind sar_port_ctrl sar_port_ctrl_chk #(.WIDTH(WIDTH), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .dac_code (dac_code),
    .result   (result),
    .ser_valid(ser_valid),
    .io_rd    (io_rd),
    .io_addr  (io_addr),
    .io_rdata (io_rdata)
);

// File: tb/sar_port_ctrl_test.sv
`timescale 1ns/1ps
module sar_port_ctrl_test;
    localparam int         W    = 8;
    localparam logic [7:0] BASE = 8'h80;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   io_addr = 8'h00;
    logic         io_rd = 1'b0;
    logic         io_wr = 1'b0;
    logic [7:0]   io_rdata;
    logic [W-1:0] dac_code;
    logic         cmp_above;
    logic         ser_bit;
    logic         ser_valid;
    int           level = 0;
    int           n_run = 0;
    int           n_fail = 0;

    always #2.5 clk = ~clk;
    assign cmp_above = (level >= int'(dac_code));

    sar_port_ctrl #(.WIDTH(W), .BASE_ADDR(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
        .io_wr(io_wr), .io_rdata(io_rdata), .dac_code(dac_code),
        .cmp_above(cmp_above), .ser_bit(ser_bit), .ser_valid(ser_valid)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called just after a falling edge; combinational read.
    task automatic port_read(input logic [7:0] a, input logic rd, output int v);
        io_addr = a; io_rd = rd;
        #0.5;
        v = int'(io_rdata);
        io_rd = 1'b0;
    endtask

    task automatic port_write(input logic [7:0] a);
        @(negedge clk);
        io_addr = a; io_wr = 1'b1;
        @(posedge clk);
        #0.5;
        io_wr = 1'b0;
    endtask

    // Follows a start; checks R1, R2, R3, R4, R5, R6.
    task automatic run_conv(input int lvl);
        int v;
        @(negedge clk);
        check("R1 half-scale trial", int'(dac_code), 1 << (W - 1));
        for (int k = 1; k <= W; k++) begin
            @(posedge clk);
            @(negedge clk);
            check("R4 strobe", int'(ser_valid), 1);
            check("R4 serial bit msb first", int'(ser_bit), (lvl >> (W - k)) & 1);
            port_read(BASE, 1'b1, v);
            check("R3 R5 busy flag", v, (k < W) ? 1 : 0);
        end
        port_read(BASE + 8'd1, 1'b1, v);
        check("R2 R6 result", v, lvl);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        port_read(BASE, 1'b1, v);       check("R9 status idle", v, 0);
        port_read(BASE + 8'd1, 1'b1, v); check("R9 result zero", v, 0);
        check("R9 dac zero", int'(dac_code), 0);
        check("R9 no strobe", int'(ser_valid), 0);

        // R8 non-start writes and unselected reads
        port_write(BASE);
        port_write(BASE + 8'd1);
        @(negedge clk);
        port_read(BASE, 1'b1, v);        check("R8 write no start", v, 0);
        check("R8 no strobe", int'(ser_valid), 0);
        check("R8 dac unchanged", int'(dac_code), 0);
        port_read(BASE + 8'd3, 1'b1, v);  check("R8 unmapped read", v, 0);
        port_read(BASE, 1'b0, v);         check("R8 read strobe low", v, 0);

        // R2 sweep over every level
        for (int lvl = 0; lvl < (1 << W); lvl++) begin
            level = lvl;
            port_write(BASE + 8'd2);
            run_conv(lvl);
        end

        // R6 result held while idle, R4 no strobes while idle
        level = 8'h5A;
        port_write(BASE + 8'd2);
        run_conv(8'h5A);
        level = 8'h11;
        repeat (4) @(posedge clk);
        @(negedge clk);
        port_read(BASE + 8'd1, 1'b1, v); check("R6 hold", v, 8'h5A);
        check("R4 idle quiet", int'(ser_valid), 0);

        // R7 restart mid-conversion
        level = 8'hAA;
        port_write(BASE + 8'd2);
        repeat (3) @(posedge clk);
        level = 8'h35;
        port_write(BASE + 8'd2);
        run_conv(8'h35);

        // R7 restart on the last step
        level = 8'hF0;
        port_write(BASE + 8'd2);
        repeat (W - 1) @(posedge clk);
        level = 8'h0F;
        port_write(BASE + 8'd2);
        run_conv(8'h0F);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule